// File: doc/BRIEF.md
# OTG Attach Power Sequencer

This block sits on the host side of an on-the-go port and decides whether the port should supply VBUS. It watches the synchronised ID level, a flag that is high while VBUS sits inside its valid band, and a one-cycle pulse that arrives once per millisecond. When ID falls, meaning an A-plug is present, the block waits through an observation window and watches for a supply already on the cable. If such a supply shows up, the block powers nothing and stays off until the plug is removed and inserted again.

If the window closes with no foreign supply, the block first enables the 5 V source. After a set gap it enables the protection switch. VBUS is then expected to rise roughly 16 ms later. Removing the plug (ID high) drops both enables at any point. A two-bit status output shows which phase the block is in.

Top module: `otg_attach_seq`

## Requirements
- R1: After reset both enables are 0 and the status is 0 (idle; the encoding is idle=0, observing=1, powered=2, rejected=3).
- R2: A high-to-low change on ID moves idle to observing one clock later. An ID that is already low when reset is released does not count as such a change.
- R3: A valid-band flag that is high while observing moves the block to rejected one clock later, with both enables left at 0.
- R4: Rejected is kept, with both enables at 0, even when the flag drops and ticks go on arriving. Only ID going high and then low again starts a new observation.
- R5: After WINDOW_MS ticks of observing with the flag low, the source enable goes to 1 and the status becomes powered. The switch enable is still 0 at that point.
- R6: The switch enable goes to 1 exactly GAP_MS ticks after the source enable, and it is never 1 while the source enable is 0.
- R7: ID high in any state clears both enables and returns the status to idle one clock later.
- R8: While powered, the valid-band flag has no effect on the enables or the status.
- R9: A flag that is high on the same clock as the last tick of the window gives rejection, not power.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_i | input | 1 | Synchronised ID level; 0 means an A-plug is present |
| vbus_ok_i | input | 1 | 1 while VBUS is inside the valid band |
| tick_ms_i | input | 1 | One-clock pulse, once per millisecond |
| src_en_o | output | 1 | Enable for the 5 V source |
| sw_en_o | output | 1 | Enable for the protection switch |
| status_o | output | 2 | Phase: 0 idle, 1 observing, 2 powered, 3 rejected |

## Verification
The tests drive a clean attach, with the flag low through the whole window. They count ticks up to one short of the window and then to its end, which shows whether the window length is exact and whether the source and switch come on in order, one gap apart. A foreign supply that appears early in the window, and one that appears on the very last tick, show whether the flag wins over expiry. Removing the plug during the gap, asserting the flag while powered, and holding ID low through reset separate the abort path from a missed fresh-event check.

// File: rtl/otg_attach_pkg.sv
package otg_attach_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_WATCH = 3'd1,
      PH_RAMP  = 3'd2,
      PH_ON    = 3'd3,
      PH_REJ   = 3'd4
   } phase_t;

   localparam logic [1:0] ST_IDLE  = 2'd0;
   localparam logic [1:0] ST_WATCH = 2'd1;
   localparam logic [1:0] ST_POWER = 2'd2;
   localparam logic [1:0] ST_REJ   = 2'd3;

   function automatic logic [1:0] phase_to_status(input phase_t ph);
      case (ph)
         PH_WATCH:      return ST_WATCH;
         PH_RAMP, PH_ON: return ST_POWER;
         PH_REJ:        return ST_REJ;
         default:       return ST_IDLE;
      endcase
   endfunction

endpackage

// File: rtl/otg_id_edge.sv
module otg_id_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic id_i,
   output logic fall_o
);
   // reset value 0: an ID already low at reset is not a fresh event
   logic id_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) id_q <= 1'b0;
      else        id_q <= id_i;
   end

   assign fall_o = id_q & ~id_i;

   AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o); // R2

endmodule

// File: rtl/otg_ms_timer.sv
module otg_ms_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   input  logic          tick_i,
   output logic          expire_o
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (load_i)                 cnt_q <= load_val_i;
      else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign expire_o = tick_i && (cnt_q == CW'(1));

   AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !tick_i) |=> $stable(cnt_q)); // R5

endmodule

// File: rtl/otg_seq_fsm.sv
module otg_seq_fsm
   import otg_attach_pkg::*;
#(
   parameter int WINDOW_MS = 200,
   parameter int GAP_MS    = 1,
   parameter int CW        = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          id_i,
   input  logic          id_fall_i,
   input  logic          vbus_ok_i,
   input  logic          tick_i,
   input  logic          expire_i,
   output logic          load_o,
   output logic [CW-1:0] load_val_o,
   output phase_t        phase_o
);
   phase_t ph_q, ph_d;
   logic   gap_done;

   generate
      if (GAP_MS == 0) begin : g_nogap
         // source still leads the switch by one clock
         assign gap_done = 1'b1;
      end else begin : g_gap
         assign gap_done = expire_i;
      end
   endgenerate

   always_comb begin
      ph_d       = ph_q;
      load_o     = 1'b0;
      load_val_o = '0;
      if (id_i) begin
         ph_d = PH_IDLE;
      end else begin
         case (ph_q)
            PH_IDLE: if (id_fall_i) begin
               ph_d       = PH_WATCH;
               load_o     = 1'b1;
               load_val_o = CW'(WINDOW_MS);
            end
            PH_WATCH: begin
               if (vbus_ok_i) ph_d = PH_REJ;
               else if (expire_i) begin
                  ph_d       = PH_RAMP;
                  load_o     = 1'b1;
                  load_val_o = CW'(GAP_MS);
               end
            end
            PH_RAMP: if (gap_done) ph_d = PH_ON;
            default: ph_d = ph_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_IDLE;
      else        ph_q <= ph_d;
   end

   assign phase_o = ph_q;

   AST_FOREIGN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_WATCH && vbus_ok_i && !id_i) |=> ph_q == PH_REJ); // R3

   AST_REJ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_REJ && !id_i) |=> ph_q == PH_REJ); // R4

   AST_TICK_IGNORED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_IDLE && !id_fall_i) |=> ph_q == PH_IDLE); // R2

endmodule

// File: rtl/otg_attach_seq.sv
module otg_attach_seq
   import otg_attach_pkg::*;
#(
   parameter int WINDOW_MS = 200,
   parameter int GAP_MS    = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       id_i,
   input  logic       vbus_ok_i,
   input  logic       tick_ms_i,
   output logic       src_en_o,
   output logic       sw_en_o,
   output logic [1:0] status_o
);
   localparam int MAXV = (WINDOW_MS > GAP_MS) ? WINDOW_MS : GAP_MS;
   localparam int CW   = $clog2(MAXV + 1);

   generate
      if (WINDOW_MS < 1) begin : g_bad_win
         $error("WINDOW_MS must be at least 1");
      end
      if (GAP_MS < 0) begin : g_bad_gap
         $error("GAP_MS must not be negative");
      end
   endgenerate

   logic          id_fall;
   logic          load;
   logic [CW-1:0] load_val;
   logic          expire;
   phase_t        phase;

   otg_id_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .id_i   (id_i),
      .fall_o (id_fall)
   );

   otg_ms_timer #(.CW(CW)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .load_val_i (load_val),
      .tick_i     (tick_ms_i),
      .expire_o   (expire)
   );

   otg_seq_fsm #(
      .WINDOW_MS (WINDOW_MS),
      .GAP_MS    (GAP_MS),
      .CW        (CW)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .id_i       (id_i),
      .id_fall_i  (id_fall),
      .vbus_ok_i  (vbus_ok_i),
      .tick_i     (tick_ms_i),
      .expire_i   (expire),
      .load_o     (load),
      .load_val_o (load_val),
      .phase_o    (phase)
   );

   assign src_en_o = (phase == PH_RAMP) || (phase == PH_ON);
   assign sw_en_o  = (phase == PH_ON);
   assign status_o = phase_to_status(phase);

   AST_ID_HIGH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      id_i |=> (!src_en_o && !sw_en_o && status_o == ST_IDLE)); // R7

   AST_SW_AFTER_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_en_o) |-> $past(src_en_o)); // R6

   AST_POWER_FROM_WATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(src_en_o) |-> $past(status_o) == ST_WATCH); // R5

   AST_POWERED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_en_o && !id_i) |=> sw_en_o); // R8

endmodule

// File: tb/sim_otg_attach_seq.sv
module sim_otg_attach_seq;
   localparam int W = 8;
   localparam int G = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic id = 1'b1;
   logic det = 1'b0;
   logic tick = 1'b0;
   logic src, sw;
   logic [1:0] st;
   int errors = 0;
   int checks = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   otg_attach_seq #(.WINDOW_MS(W), .GAP_MS(G)) u0 (
      .clk(clk), .rst_n(rst_n), .id_i(id), .vbus_ok_i(det), .tick_ms_i(tick),
      .src_en_o(src), .sw_en_o(sw), .status_o(st)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic outs(input string req, input int s, input int e_src, input int e_sw);
      chk({req, " status"}, int'(st), s);
      chk({req, " src_en"}, int'(src), e_src);
      chk({req, " sw_en"}, int'(sw), e_sw);
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1; @(negedge clk);
         tick = 1'b0; @(negedge clk);
      end
   endtask

   task automatic attach();
      id = 1'b1; step(1);
      id = 1'b0; step(1);
   endtask

   task automatic t_reset();
      outs("R1 reset", 0, 0, 0);
   endtask

   task automatic t_accept();
      attach();
      outs("R2 observe", 1, 0, 0);
      ticks(W - 1);
      outs("R5 window not yet over", 1, 0, 0);
      ticks(1);
      outs("R5 source on", 2, 1, 0);
      ticks(G - 1);
      outs("R6 gap not yet over", 2, 1, 0);
      ticks(1);
      outs("R6 switch on", 2, 1, 1);
      det = 1'b1; ticks(3);
      outs("R8 flag while powered", 2, 1, 1);
      det = 1'b0; step(2);
      outs("R8 flag dropped while powered", 2, 1, 1);
      id = 1'b1; step(1);
      outs("R7 unplug while on", 0, 0, 0);
   endtask

   task automatic t_reject();
      attach();
      ticks(3);
      det = 1'b1; step(1);
      outs("R3 foreign supply", 3, 0, 0);
      det = 1'b0; ticks(2 * W);
      outs("R4 reject sticky", 3, 0, 0);
      attach();
      outs("R4 fresh event restarts", 1, 0, 0);
      ticks(W - 1);
      det = 1'b1; tick = 1'b1; step(1);
      det = 1'b0; tick = 1'b0;
      outs("R9 flag on last tick", 3, 0, 0);
      ticks(2);
      outs("R9 stays rejected", 3, 0, 0);
   endtask

   task automatic t_abort_gap();
      attach();
      ticks(W);
      outs("R5 source on again", 2, 1, 0);
      ticks(1);
      id = 1'b1; step(1);
      outs("R7 unplug during gap", 0, 0, 0);
      ticks(G + 2);
      outs("R7 stays idle", 0, 0, 0);
   endtask

   task automatic t_no_fresh();
      id = 1'b0;
      rst_n = 1'b0; step(2);
      rst_n = 1'b1; step(1);
      ticks(W + G + 2);
      outs("R2 low ID at reset is no event", 0, 0, 0);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=done", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_accept();
      t_reject();
      t_abort_gap();
      t_no_fresh();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule